// File: doc/BRIEF.md
# Receive Link Bring-Up Sequencer

This block brings a source-synchronous receive link out of reset and into word alignment. It runs once when reset is released and again whenever a restart is requested. It drives the reset lines of the clock synthesizer, the phase aligner, the clock-crossing FIFO and the bitslip stage in a fixed order. Each step is released only when the lock indications of the previous step allow it. Once the resets are done, the block searches for the word boundary. It compares each parallel word with an expected control word and requests one bitslip for every mismatch. It waits a settle interval after each slip so that the stale word has cleared before the next compare.

A mode input selects between phase-aligned reception and plain clock-aligned reception. In the plain mode the phase aligner stays in reset and the FIFO step is skipped. After a configurable number of slips without a match, the block raises an error flag and restarts the search from the bitslip reset. A match asserts link-ready. A restart request withdraws link-ready in the same cycle.

Top module: `link_bringup_seq`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after a clock edge that samples `start_i` high, `pll_rst_o` and `pa_rst_o` are 1 and `fifo_rst_o`, `slip_rst_o`, `slip_o` and `link_ready_o` are 0.
- R2: `pll_rst_o` stays high for exactly PLL_RST_CYC cycles, counted from reset release or from the restart edge, and is then released.
- R3: In phase-aligned mode (`dpa_mode_i`=1), `pa_rst_o` is released only after `pll_locked_i` has been sampled high on LOCK_STABLE_CYC consecutive edges. Any low sample restarts that count.
- R4: In plain mode (`dpa_mode_i`=0, sampled while `pll_rst_o` is high), `pa_rst_o` stays 1 and `fifo_rst_o` never pulses. The bitslip reset follows directly once the lock is stable.
- R5: In phase-aligned mode, the first edge that samples `pa_locked_i` high starts a `fifo_rst_o` pulse of FIFO_RST_CYC cycles.
- R6: `slip_rst_o` goes high FIFO_GAP_CYC cycles after `fifo_rst_o` falls and stays high for SLIP_RST_CYC cycles.
- R7: Each compare that finds `rx_word_i` != `ctrl_word_i` (all WORD_W bits) produces one `slip_o` pulse one cycle wide. SETTLE_CYC cycles separate every slip or bitslip reset from the next compare.
- R8: A compare with `rx_word_i` == `ctrl_word_i` sets `link_ready_o` to 1 in the next cycle. No further slips or bitslip resets follow.
- R9: `link_ready_o` goes to 0 in the same cycle that `start_i` goes high.
- R10: If a compare mismatches after ROLLOVER slips, `align_err_o` goes to 1 and a new bitslip reset starts the search again. `align_err_o` returns to 0 on a match or a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart request |
| pll_locked_i | input | 1 | Clock synthesizer lock indication |
| pa_locked_i | input | 1 | Phase aligner lock indication |
| dpa_mode_i | input | 1 | 1 = phase-aligned mode, 0 = plain mode |
| rx_word_i | input | WORD_W | Received parallel word |
| ctrl_word_i | input | WORD_W | Expected control word |
| pll_rst_o | output | 1 | Clock synthesizer reset |
| pa_rst_o | output | 1 | Phase aligner reset |
| fifo_rst_o | output | 1 | Clock-crossing FIFO reset |
| slip_rst_o | output | 1 | Bitslip stage reset |
| slip_o | output | 1 | Bitslip request pulse |
| link_ready_o | output | 1 | Word boundary found |
| align_err_o | output | 1 | Search exhausted without a match |

## Verification
The first run is in phase-aligned mode. The synthesizer lock drops for one cycle before it holds steady, which shows whether the stability count really restarts rather than just accumulating high samples. The aligner lock then arrives late, so the FIFO pulse can be told apart from a release that runs on timers alone. The control word appears after two mismatches, which fixes the spacing between slips and the exact cycle of link-ready. A restart into plain mode with a word that never matches drives the slip counter through its rollover, raises the error and starts a second search. That search is then allowed to succeed.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  typedef enum logic [3:0] {
    ST_PLL_RST,
    ST_PLL_WAIT,
    ST_PA_WAIT,
    ST_FIFO_RST,
    ST_FIFO_GAP,
    ST_SLIP_RST,
    ST_SETTLE,
    ST_COMPARE,
    ST_SLIP,
    ST_READY
  } seq_state_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lock_filter.sv
module lock_filter #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lock_i,
  output logic stable_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i || !lock_i)           cnt_q <= '0;
    else if (cnt_q != CW'(STABLE_CYC))   cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = (cnt_q == CW'(STABLE_CYC));

  AST_LOCK_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(STABLE_CYC)); // R3
  AST_LOCK_DROP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !stable_o); // R3

endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == limit_i - 1'b1);

endmodule

// File: rtl/word_search.sv
module word_search #(
  parameter int WORD_W   = 10,
  parameter int ROLLOVER = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  output logic              match_o,
  output logic              exhausted_o
);
  localparam int SW = $clog2(ROLLOVER + 1);

  logic [SW-1:0] slips_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   slips_q <= '0;
    else if (clr_i)                slips_q <= '0;
    else if (inc_i && !exhausted_o) slips_q <= slips_q + 1'b1;
  end

  assign match_o     = (rx_word_i == ctrl_word_i);
  assign exhausted_o = (slips_q == SW'(ROLLOVER));

  AST_SLIP_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slips_q <= SW'(ROLLOVER)); // R10

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import link_seq_pkg::*;
#(
  parameter int WORD_W          = 10,
  parameter int PLL_RST_CYC     = 4,
  parameter int LOCK_STABLE_CYC = 4,
  parameter int FIFO_RST_CYC    = 1,
  parameter int FIFO_GAP_CYC    = 2,
  parameter int SLIP_RST_CYC    = 1,
  parameter int SETTLE_CYC      = 2,
  parameter int ROLLOVER        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pll_locked_i,
  input  logic              pa_locked_i,
  input  logic              dpa_mode_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  output logic              pll_rst_o,
  output logic              pa_rst_o,
  output logic              fifo_rst_o,
  output logic              slip_rst_o,
  output logic              slip_o,
  output logic              link_ready_o,
  output logic              align_err_o
);
  localparam int MAX_DWELL = max_of4(max_of4(PLL_RST_CYC, FIFO_RST_CYC, FIFO_GAP_CYC, 1),
                                     SLIP_RST_CYC, SETTLE_CYC, 1);
  localparam int TW = $clog2(MAX_DWELL + 1) + 1;

  seq_state_e state_q, state_d;
  logic       mode_q;
  logic       err_q;
  logic       tmr_done, pll_stable, match, exhausted;
  logic [TW-1:0] limit;

  lock_filter #(.STABLE_CYC(LOCK_STABLE_CYC)) u_pll_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_PLL_RST),
    .lock_i   (pll_locked_i),
    .stable_o (pll_stable)
  );

  always_comb begin
    unique case (state_q)
      ST_PLL_RST:  limit = TW'(PLL_RST_CYC);
      ST_FIFO_RST: limit = TW'(FIFO_RST_CYC);
      ST_FIFO_GAP: limit = TW'(FIFO_GAP_CYC);
      ST_SLIP_RST: limit = TW'(SLIP_RST_CYC);
      ST_SETTLE:   limit = TW'(SETTLE_CYC);
      default:     limit = TW'(1);
    endcase
  end

  dwell_timer #(.CNT_W(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i || (state_d != state_q)),
    .limit_i (limit),
    .done_o  (tmr_done)
  );

  word_search #(.WORD_W(WORD_W), .ROLLOVER(ROLLOVER)) u_search (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (state_q == ST_SLIP_RST || state_q == ST_PLL_RST),
    .inc_i       (state_q == ST_COMPARE && state_d == ST_SLIP),
    .rx_word_i   (rx_word_i),
    .ctrl_word_i (ctrl_word_i),
    .match_o     (match),
    .exhausted_o (exhausted)
  );

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_PLL_RST;
    end else begin
      unique case (state_q)
        ST_PLL_RST:  if (tmr_done)   state_d = ST_PLL_WAIT;
        ST_PLL_WAIT: if (pll_stable) state_d = mode_q ? ST_PA_WAIT : ST_SLIP_RST;
        ST_PA_WAIT:  if (pa_locked_i) state_d = ST_FIFO_RST;
        ST_FIFO_RST: if (tmr_done)   state_d = ST_FIFO_GAP;
        ST_FIFO_GAP: if (tmr_done)   state_d = ST_SLIP_RST;
        ST_SLIP_RST: if (tmr_done)   state_d = ST_SETTLE;
        ST_SETTLE:   if (tmr_done)   state_d = ST_COMPARE;
        ST_COMPARE: begin
          if (match)          state_d = ST_READY;
          else if (exhausted) state_d = ST_SLIP_RST;
          else                state_d = ST_SLIP;
        end
        ST_SLIP:     state_d = ST_SETTLE;
        ST_READY:    state_d = ST_READY;
        default:     state_d = ST_PLL_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PLL_RST;
      mode_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_PLL_RST) mode_q <= dpa_mode_i;
      if (start_i)
        err_q <= 1'b0;
      else if (state_q == ST_COMPARE)
        err_q <= match ? 1'b0 : (exhausted ? 1'b1 : err_q);
    end
  end

  // mode-dependent: plain mode keeps the aligner parked
  assign pll_rst_o    = (state_q == ST_PLL_RST);
  assign pa_rst_o     = (state_q == ST_PLL_RST) || (state_q == ST_PLL_WAIT) || !mode_q;
  assign fifo_rst_o   = (state_q == ST_FIFO_RST);
  assign slip_rst_o   = (state_q == ST_SLIP_RST);
  assign slip_o       = (state_q == ST_SLIP);
  assign link_ready_o = (state_q == ST_READY) && !start_i;
  assign align_err_o  = err_q;

  AST_PLL_WITH_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> pa_rst_o); // R1
  AST_RESTART_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pll_rst_o && pa_rst_o && !slip_o)); // R1
  AST_PA_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pa_rst_o) |-> $past(pll_stable)); // R3
  AST_FIFO_NOT_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |-> !pa_rst_o); // R4
  AST_SLIP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o); // R7
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_ready_o |-> (!slip_o && !slip_rst_o && !fifo_rst_o)); // R8
  AST_ERR_RESEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(align_err_o) && !$past(start_i)) |-> slip_rst_o); // R10

endmodule

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;

  localparam int WW = 10;
  localparam logic [WW-1:0] CTRL = 10'h0F8;
  localparam logic [WW-1:0] BAD  = 10'h155;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pll_lk = 1'b0, pa_lk = 1'b0, mode = 1'b1;
  logic [WW-1:0] rx = BAD;
  logic pll_rst, pa_rst, fifo_rst, slip_rst, slip, ready, err;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    int         at;
    logic [6:0] mask;
    logic [6:0] val;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  link_bringup_seq #(.WORD_W(WW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pll_locked_i(pll_lk),
    .pa_locked_i(pa_lk), .dpa_mode_i(mode), .rx_word_i(rx), .ctrl_word_i(CTRL),
    .pll_rst_o(pll_rst), .pa_rst_o(pa_rst), .fifo_rst_o(fifo_rst),
    .slip_rst_o(slip_rst), .slip_o(slip), .link_ready_o(ready), .align_err_o(err)
  );

  function automatic logic [6:0] outs();
    return {err, ready, slip, slip_rst, fifo_rst, pa_rst, pll_rst};
  endfunction

  task automatic push(int at, logic [6:0] mask, logic [6:0] val, string req);
    exp_t e;
    e.at = at; e.mask = mask; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic chk(string req, logic [6:0] act, logic [6:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, expv);
    end
  endtask

  task automatic wait_cyc(int k);
    wait (cyc >= k);
    @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // monitor: bit order {err,ready,slip,slip_rst,fifo_rst,pa_rst,pll_rst}
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      cyc++;
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].at == cyc) begin
          chk(exp_q[i].req, outs() & exp_q[i].mask, exp_q[i].val);
          exp_q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1", outs(), 7'b0000011);

    push(3,  7'h03, 7'h03, "R2");
    push(4,  7'h03, 7'h02, "R2");
    push(13, 7'h02, 7'h02, "R3");
    push(14, 7'h06, 7'h00, "R3");
    push(16, 7'h04, 7'h00, "R5");
    push(17, 7'h04, 7'h04, "R5");
    push(18, 7'h0C, 7'h00, "R5");
    push(19, 7'h08, 7'h00, "R6");
    push(20, 7'h08, 7'h08, "R6");
    push(21, 7'h18, 7'h00, "R6");
    push(23, 7'h10, 7'h00, "R7");
    push(24, 7'h10, 7'h10, "R7");
    push(25, 7'h10, 7'h00, "R7");
    push(26, 7'h10, 7'h00, "R7");
    push(27, 7'h10, 7'h00, "R7");
    push(28, 7'h10, 7'h10, "R7");
    push(31, 7'h30, 7'h00, "R8");
    push(32, 7'h30, 7'h20, "R8");
    push(33, 7'h38, 7'h20, "R8");

    // lock glitch: high 2 edges, low 1, then steady (R3)
    wait_cyc(6);  pll_lk = 1'b1;
    wait_cyc(8);  pll_lk = 1'b0;
    wait_cyc(9);  pll_lk = 1'b1;
    wait_cyc(16); pa_lk = 1'b1;
    wait_cyc(29); rx = CTRL;

    push(35, 7'h23, 7'h03, "R1");
    push(38, 7'h01, 7'h01, "R2");
    push(39, 7'h03, 7'h02, "R4");
    push(43, 7'h08, 7'h00, "R4");
    push(44, 7'h0E, 7'h0A, "R4");
    push(45, 7'h06, 7'h02, "R4");
    push(84, 7'h50, 7'h10, "R10");
    push(87, 7'h48, 7'h00, "R10");
    push(88, 7'h58, 7'h48, "R10");
    push(92, 7'h50, 7'h50, "R10");
    push(96, 7'h60, 7'h20, "R10");

    wait_cyc(34);
    chk("R8", {6'b0, ready}, 7'b1);
    rx = BAD; mode = 1'b0; start = 1'b1;
    #1 chk("R9", {6'b0, ready}, 7'b0);
    wait_cyc(35); start = 1'b0;
    wait_cyc(92); rx = CTRL;
    wait_cyc(100);
    chk("R8", 7'(exp_q.size()), 7'd0);
    report();
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    report();
  end

endmodule